// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits beside a small 16-bit processor core and decides when ordinary execution must give way to exception handling. It watches three sources: the active-low reset pin, a pending interrupt request with its vector number, and a strobe that the core raises when it executes a trap instruction. When it accepts a source, it runs the entry sequence on a simple request/acknowledge memory port. For an interrupt or a trap, that means one stack write. For every source, that means one vector-table read. The sequence ends with a one-cycle load pulse that hands the core its new program counter, condition code register and stack pointer.

Interrupt acceptance is tied to instruction boundaries and to the end of a running entry sequence. It is withheld after any instruction that rewrote the condition code register, and after a reset entry. A trap is taken on any cycle in which the core is running normally. The saved context is one 32-bit word: the condition code byte sits in bits 31:24 and the 24-bit program counter in bits 23:0. The word is written at the stack pointer minus 4.

Top module: `exc_entry_seq`

## Requirements
- R1: Reset outranks everything. When an interrupt and a trap are both acceptable in the same idle cycle, the interrupt entry runs first. The displaced trap entry then follows directly from the interrupt's load cycle.
- R2: While `rst_n` is low, `busy` is 1 and `bus_req` is 0. On the first clock edge with `rst_n` high, a read of address 0 (vector 0) starts. No stack write is made for reset.
- R3: A reset entry ends with `ctx_load` = 1, `pc_new` equal to the word read, `ccr_new` = 0x80 and `sp_new` = 0.
- R4: An interrupt request is accepted from idle only in a cycle with `insn_end` = 1 and `insn_ccr_mod` = 0. In any other idle cycle, `busy` stays 0.
- R5: An interrupt request that is present in the load cycle of an interrupt or trap entry starts a new entry at once. The context it saves is the handler address just loaded, together with the new CCR.
- R6: An interrupt request present in the load cycle of a reset entry is not taken, and the block returns to idle.
- R7: A trap strobe in any idle cycle is accepted, whatever the values of `insn_end` and `insn_ccr_mod`.
- R8: An interrupt or trap entry writes one word, {ccr[7:0], pc[23:0]}, at address `sp_in` − 4. After that write, `sp_new` equals that address.
- R9: The vector read uses address vector × 4. `pc_new` takes the 24-bit word that is returned.
- R10: The CCR presented at load is the saved CCR with bit 7 (interrupt mask) set to 1.
- R11: `busy` is 1 from the cycle after acceptance through the `ctx_load` cycle, and 0 in idle.
- R12: Taking `rst_n` low during a sequence abandons it. `bus_req` is 0 on the next cycle, and a fresh reset entry follows the release.
- R13: A bus request keeps its address, direction and write data unchanged until `bus_ack` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, also the reset exception source |
| irq_req | input | 1 | Interrupt pending, already masked by the interrupt controller |
| irq_vec | input | VEC_W | Vector number of the pending interrupt |
| trap_req | input | 1 | Trap instruction executing this cycle |
| trap_vec | input | VEC_W | Vector number of the trap |
| insn_end | input | 1 | The current instruction completes this cycle |
| insn_ccr_mod | input | 1 | The completing instruction is one of the CCR-rewriting classes |
| pc_in | input | PC_W | Return address to save |
| ccr_in | input | CCR_W | Current condition code register |
| sp_in | input | ADDR_W | Current stack pointer |
| bus_req | output | 1 | Memory request |
| bus_we | output | 1 | 1 = write (stack push), 0 = read (vector) |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Request completes this cycle |
| bus_rdata | input | PC_W | Vector entry (handler address) |
| busy | output | 1 | Entry sequence in progress |
| ctx_load | output | 1 | One-cycle pulse: load the new PC, CCR and SP |
| pc_new | output | PC_W | Handler address |
| ccr_new | output | CCR_W | CCR to load |
| sp_new | output | ADDR_W | Stack pointer to load |

## Verification
Some rules are checked by assertions on every cycle:
- an idle-to-push transition for an interrupt happens only on a clean instruction boundary;
- a reset load never chains;
- the stack pointer follows the address of each acknowledged write;
- a pending request holds steady;
- a trap strobe in idle always raises `busy`.

Other behaviour needs the bench's scenarios. These include the order of a displaced trap behind an interrupt, the context saved by a chained entry, the abort of a sequence by reset and the reset-state outputs. The scoreboard compares every bus transfer and every load pulse, in order, against values computed from the requirements.

// File: rtl/exc_pkg.sv
// Shared types for the exception entry sequencer.
// Assumes a CCR of at least 8 bits with the interrupt mask in bit 7.
package exc_pkg;

    typedef enum logic [2:0] {
        ST_RST,
        ST_IDLE,
        ST_PUSH,
        ST_FETCH,
        ST_LOAD
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_RESET,
        SRC_IRQ,
        SRC_TRAP
    } exc_src_t;

    localparam int IMASK_BIT = 7;

endpackage

// File: rtl/exc_arbiter.sv
// Source selection for exception entry.
// Decides whether a source is taken this cycle, which one and with which vector.
// Assumes irq_req has already passed the interrupt controller's masking.
// Reset does not pass through here: it acts on the sequencer's state directly.
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  seq_state_t         state,
    input  exc_src_t           cur_src,
    input  logic               irq_req,
    input  logic [VEC_W-1:0]   irq_vec,
    input  logic               trap_req,
    input  logic [VEC_W-1:0]   trap_vec,
    input  logic               insn_end,
    input  logic               insn_ccr_mod,
    input  logic               trap_pend,
    input  logic [VEC_W-1:0]   trap_pend_vec,
    output logic               take,
    output exc_src_t           take_src,
    output logic [VEC_W-1:0]   take_vec,
    output logic               defer_trap
);

    logic in_idle;
    logic at_chain;
    logic irq_ok;
    logic trap_ok;

    // Work out acceptance windows and priority between interrupt and trap.
    always_comb begin
        in_idle  = (state == ST_IDLE);
        at_chain = (state == ST_LOAD) && (cur_src != SRC_RESET);
        irq_ok   = irq_req && ((in_idle && insn_end && !insn_ccr_mod) || at_chain);
        trap_ok  = (in_idle && trap_req) || (at_chain && trap_pend);
        take     = irq_ok || trap_ok;
        take_src = irq_ok ? SRC_IRQ : SRC_TRAP;
        if (irq_ok) begin
            take_vec = irq_vec;
        end else if (in_idle) begin
            take_vec = trap_vec;
        end else begin
            take_vec = trap_pend_vec;
        end
        defer_trap = in_idle && trap_req && irq_ok;
    end

endmodule

// File: rtl/exc_bus_port.sv
// Memory request formation.
// Turns the sequencer state into a write of the saved context or a vector read.
// Assumes ADDR_W > VEC_W + 2, so that a vector address fits.
module exc_bus_port
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CCR_W  = 8,
    parameter int VEC_W  = 8
) (
    input  seq_state_t                state,
    input  logic [ADDR_W-1:0]         sp_q,
    input  logic [CCR_W-1:0]          sv_ccr,
    input  logic [DATA_W-CCR_W-1:0]   sv_pc,
    input  logic [VEC_W-1:0]          cur_vec,
    output logic                      bus_req,
    output logic                      bus_we,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [DATA_W-1:0]         bus_wdata
);

    localparam int PAD_W = ADDR_W - VEC_W - 2;

    logic [ADDR_W-1:0] vec_addr;
    logic [ADDR_W-1:0] push_addr;

    // Drive the request from the state: a push in PUSH, a read in FETCH.
    always_comb begin
        vec_addr  = {{PAD_W{1'b0}}, cur_vec, 2'b00};
        push_addr = sp_q - ADDR_W'(4);
        bus_req   = (state == ST_PUSH) || (state == ST_FETCH);
        bus_we    = (state == ST_PUSH);
        bus_addr  = (state == ST_PUSH) ? push_addr : vec_addr;
        bus_wdata = (state == ST_PUSH) ? {sv_ccr, sv_pc} : '0;
    end

endmodule

// File: rtl/exc_seq_ctrl.sv
// Entry sequence state machine and context registers.
// Holds the saved PC, CCR and SP and the vector being served.
// Also holds a trap that lost to an interrupt in the same cycle.
// Assumes the core is stalled while busy, so that no new trap strobe arrives then.
module exc_seq_ctrl
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CCR_W  = 8,
    parameter int VEC_W  = 8,
    localparam int PC_W  = DATA_W - CCR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  exc_src_t           take_src,
    input  logic [VEC_W-1:0]   take_vec,
    input  logic               defer_trap,
    input  logic [VEC_W-1:0]   trap_vec,
    input  logic [PC_W-1:0]    pc_in,
    input  logic [CCR_W-1:0]   ccr_in,
    input  logic [ADDR_W-1:0]  sp_in,
    input  logic               bus_ack,
    input  logic [PC_W-1:0]    vec_word,
    output seq_state_t         state,
    output exc_src_t           cur_src,
    output logic [VEC_W-1:0]   cur_vec,
    output logic [ADDR_W-1:0]  sp_q,
    output logic [PC_W-1:0]    sv_pc,
    output logic [CCR_W-1:0]   sv_ccr,
    output logic [PC_W-1:0]    pc_q,
    output logic [CCR_W-1:0]   ccr_q,
    output logic               trap_pend,
    output logic [VEC_W-1:0]   trap_pend_vec
);

    localparam logic [CCR_W-1:0] IMASK = CCR_W'(1) << IMASK_BIT;

    // Advance the sequence and capture context; reset aborts any state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_RST;
            cur_src       <= SRC_RESET;
            cur_vec       <= '0;
            sp_q          <= '0;
            sv_pc         <= '0;
            sv_ccr        <= '0;
            pc_q          <= '0;
            ccr_q         <= '0;
            trap_pend     <= 1'b0;
            trap_pend_vec <= '0;
        end else begin
            case (state)
                ST_RST: begin
                    state   <= ST_FETCH;
                    cur_src <= SRC_RESET;
                    cur_vec <= '0;
                    sv_ccr  <= '0;
                end
                ST_IDLE: begin
                    if (take) begin
                        state   <= ST_PUSH;
                        cur_src <= take_src;
                        cur_vec <= take_vec;
                        sv_pc   <= pc_in;
                        sv_ccr  <= ccr_in;
                        sp_q    <= sp_in;
                        if (defer_trap) begin
                            trap_pend     <= 1'b1;
                            trap_pend_vec <= trap_vec;
                        end
                    end
                end
                ST_PUSH: begin
                    if (bus_ack) begin
                        sp_q  <= sp_q - ADDR_W'(4);
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (bus_ack) begin
                        pc_q  <= vec_word;
                        ccr_q <= sv_ccr | IMASK;
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (take) begin
                        state   <= ST_PUSH;
                        cur_src <= take_src;
                        cur_vec <= take_vec;
                        sv_pc   <= pc_q;
                        sv_ccr  <= ccr_q;
                        if (take_src == SRC_TRAP) begin
                            trap_pend <= 1'b0;
                        end
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_RST;
            endcase
        end
    end

    // R6: the load that ends a reset entry goes back to idle, never into a new entry.
    p_reset_no_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && cur_src == SRC_RESET) |=> (state == ST_IDLE));

    // R2: a reset entry never reaches the stack push.
    p_reset_no_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH) |-> (cur_src != SRC_RESET));

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer (top).
// Picks reset, interrupt or trap and pushes the context for interrupts and traps.
// Then reads the vector table and pulses ctx_load with the new PC, CCR and SP.
// Assumes a memory port that holds bus_ack for one cycle per request.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CCR_W  = 8,
    parameter int VEC_W  = 8,
    localparam int PC_W  = DATA_W - CCR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_req,
    input  logic [VEC_W-1:0]   irq_vec,
    input  logic               trap_req,
    input  logic [VEC_W-1:0]   trap_vec,
    input  logic               insn_end,
    input  logic               insn_ccr_mod,
    input  logic [PC_W-1:0]    pc_in,
    input  logic [CCR_W-1:0]   ccr_in,
    input  logic [ADDR_W-1:0]  sp_in,
    output logic               bus_req,
    output logic               bus_we,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ack,
    input  logic [PC_W-1:0]    bus_rdata,
    output logic               busy,
    output logic               ctx_load,
    output logic [PC_W-1:0]    pc_new,
    output logic [CCR_W-1:0]   ccr_new,
    output logic [ADDR_W-1:0]  sp_new
);

    seq_state_t        state;
    exc_src_t          cur_src;
    exc_src_t          take_src;
    logic              take;
    logic              defer_trap;
    logic [VEC_W-1:0]  take_vec;
    logic [VEC_W-1:0]  cur_vec;
    logic [VEC_W-1:0]  trap_pend_vec;
    logic              trap_pend;
    logic [ADDR_W-1:0] sp_q;
    logic [PC_W-1:0]   sv_pc;
    logic [CCR_W-1:0]  sv_ccr;
    logic [PC_W-1:0]   pc_q;
    logic [CCR_W-1:0]  ccr_q;

    exc_arbiter #(.VEC_W(VEC_W)) u_arb (
        .state         (state),
        .cur_src       (cur_src),
        .irq_req       (irq_req),
        .irq_vec       (irq_vec),
        .trap_req      (trap_req),
        .trap_vec      (trap_vec),
        .insn_end      (insn_end),
        .insn_ccr_mod  (insn_ccr_mod),
        .trap_pend     (trap_pend),
        .trap_pend_vec (trap_pend_vec),
        .take          (take),
        .take_src      (take_src),
        .take_vec      (take_vec),
        .defer_trap    (defer_trap)
    );

    exc_seq_ctrl #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CCR_W (CCR_W), .VEC_W (VEC_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (take),
        .take_src      (take_src),
        .take_vec      (take_vec),
        .defer_trap    (defer_trap),
        .trap_vec      (trap_vec),
        .pc_in         (pc_in),
        .ccr_in        (ccr_in),
        .sp_in         (sp_in),
        .bus_ack       (bus_ack),
        .vec_word      (bus_rdata),
        .state         (state),
        .cur_src       (cur_src),
        .cur_vec       (cur_vec),
        .sp_q          (sp_q),
        .sv_pc         (sv_pc),
        .sv_ccr        (sv_ccr),
        .pc_q          (pc_q),
        .ccr_q         (ccr_q),
        .trap_pend     (trap_pend),
        .trap_pend_vec (trap_pend_vec)
    );

    exc_bus_port #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CCR_W (CCR_W), .VEC_W (VEC_W)
    ) u_bus (
        .state     (state),
        .sp_q      (sp_q),
        .sv_ccr    (sv_ccr),
        .sv_pc     (sv_pc),
        .cur_vec   (cur_vec),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    // Present the status and load outputs to the core.
    always_comb begin
        busy     = (state != ST_IDLE);
        ctx_load = (state == ST_LOAD);
        pc_new   = pc_q;
        ccr_new  = ccr_q;
        sp_new   = sp_q;
    end

    // R4: an interrupt leaves idle only on a boundary where the CCR was not rewritten.
    p_irq_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state == ST_PUSH && cur_src == SRC_IRQ)
        |-> $past(insn_end && !insn_ccr_mod));

    // R8: after an acknowledged push, the stack pointer output equals the address written.
    p_sp_follows_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_ack) |=> (sp_new == $past(bus_addr)));

    // R13: a request that is not acknowledged is held unchanged.
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_we) && $stable(bus_wdata)));

    // R7: a trap strobe seen in idle always starts a sequence.
    p_trap_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trap_req) |=> busy);

endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_vec = '0;
    logic        insn_end = 1'b0;
    logic        insn_ccr_mod = 1'b0;
    logic [23:0] pc_in = '0;
    logic [7:0]  ccr_in = '0;
    logic [31:0] sp_in = '0;
    logic        bus_req, bus_we, busy, ctx_load;
    logic [31:0] bus_addr, bus_wdata, sp_new;
    logic        bus_ack = 1'b0;
    logic [23:0] bus_rdata = '0;
    logic [23:0] pc_new;
    logic [7:0]  ccr_new;

    exc_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
        .trap_req(trap_req), .trap_vec(trap_vec), .insn_end(insn_end),
        .insn_ccr_mod(insn_ccr_mod), .pc_in(pc_in), .ccr_in(ccr_in), .sp_in(sp_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .ctx_load(ctx_load),
        .pc_new(pc_new), .ccr_new(ccr_new), .sp_new(sp_new)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          kind;   // 0 write, 1 read, 2 load
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    lat = 0;
    logic [31:0] req_addr = '0;

    function automatic logic [23:0] hnd(input logic [31:0] a);
        return (a[23:0] << 4) + 24'h000100;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push_item(input int k, input logic [31:0] a, input logic [31:0] d, input string tag);
        item_t it;
        it.kind = k; it.a = a; it.d = d; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Expected traffic of one interrupt or trap entry.
    task automatic exp_entry(input logic [31:0] sp0, input logic [7:0] ccr,
                             input logic [23:0] pc, input logic [7:0] vec, input string tag);
        logic [31:0] va;
        va = {22'b0, vec, 2'b00};
        push_item(0, sp0 - 32'd4, {ccr, pc}, {tag, "/R8"});
        push_item(1, va, 32'h0, {tag, "/R9"});
        push_item(2, sp0 - 32'd4, {ccr | 8'h80, hnd(va)}, {tag, "/R10"});
    endtask

    task automatic wait_load();
        do @(negedge clk); while (!ctx_load);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    // Memory model: acknowledges after LAT cycles; R13 checks the address held steady.
    always @(posedge clk) begin
        if (!bus_req || bus_ack) begin
            lat <= 0;
            bus_ack <= 1'b0;
        end else if (lat == LAT) begin
            chk("R13 address held", bus_addr, req_addr);
            bus_ack <= 1'b1;
            bus_rdata <= hnd(bus_addr);
            lat <= 0;
        end else begin
            if (lat == 0) req_addr <= bus_addr;
            lat <= lat + 1;
        end
    end

    // Monitor: pops the expected item for each transfer or load pulse.
    always @(negedge clk) begin
        if (rst_n && ((bus_req && bus_ack) || ctx_load)) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL unexpected event: actual addr %h expected none", bus_addr);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                if (ctx_load) begin
                    chk({it.tag, " kind"}, 32'(2), 32'(it.kind));
                    chk({it.tag, " sp"}, sp_new, it.a);
                    chk({it.tag, " ccr/pc"}, {ccr_new, pc_new}, it.d);
                end else begin
                    chk({it.tag, " kind"}, 32'(!bus_we), 32'(it.kind));
                    chk({it.tag, " addr"}, bus_addr, it.a);
                    if (bus_we) chk({it.tag, " data"}, bus_wdata, it.d);
                end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        // R2: reset state, with an interrupt held pending throughout.
        irq_req = 1'b1; irq_vec = 8'd5;
        repeat (3) @(negedge clk);
        chk("R2 busy in reset", 32'(busy), 32'd1);
        chk("R2 no request in reset", 32'(bus_req), 32'd0);
        push_item(1, 32'h0, 32'h0, "R2 vector 0");
        push_item(2, 32'h0, {8'h80, hnd(32'h0)}, "R3 reset load");
        rst_n = 1'b1;
        wait_load();
        @(negedge clk);
        chk("R6 no chain after reset", 32'(busy), 32'd0);
        irq_req = 1'b0;

        // R4: boundary gating of interrupts.
        sp_in = 32'h1000; pc_in = 24'h123456; ccr_in = 8'h05;
        irq_req = 1'b1; irq_vec = 8'd12; insn_end = 1'b1; insn_ccr_mod = 1'b1;
        @(negedge clk);
        chk("R4 blocked after CCR op", 32'(busy), 32'd0);
        insn_end = 1'b0; insn_ccr_mod = 1'b0;
        @(negedge clk);
        chk("R4 blocked mid instruction", 32'(busy), 32'd0);
        insn_end = 1'b1;
        exp_entry(32'h1000, 8'h05, 24'h123456, 8'd12, "R4");
        @(negedge clk);
        chk("R11 busy after accept", 32'(busy), 32'd1);
        irq_req = 1'b0; insn_end = 1'b0;
        wait_load();
        @(negedge clk);
        chk("R11 idle after load", 32'(busy), 32'd0);

        // R7: trap taken regardless of the boundary signals.
        sp_in = 32'h2000; pc_in = 24'h000ABC; ccr_in = 8'h40;
        insn_ccr_mod = 1'b1; trap_req = 1'b1; trap_vec = 8'd9;
        exp_entry(32'h2000, 8'h40, 24'h000ABC, 8'd9, "R7");
        @(negedge clk);
        trap_req = 1'b0; insn_ccr_mod = 1'b0;
        chk("R7 trap accepted", 32'(busy), 32'd1);
        wait_idle();

        // R1: interrupt and trap together; the trap follows the interrupt.
        sp_in = 32'h4000; pc_in = 24'h00BEEF; ccr_in = 8'h12;
        irq_req = 1'b1; irq_vec = 8'd20; trap_req = 1'b1; trap_vec = 8'd10; insn_end = 1'b1;
        exp_entry(32'h4000, 8'h12, 24'h00BEEF, 8'd20, "R1 irq first");
        exp_entry(32'h3FFC, 8'h92, hnd(32'd80), 8'd10, "R1 trap second");
        @(negedge clk);
        irq_req = 1'b0; trap_req = 1'b0; insn_end = 1'b0;
        wait_load();
        @(negedge clk);
        chk("R1 trap chained", 32'(busy), 32'd1);
        wait_idle();

        // R5: interrupt pending at the end of a trap entry chains.
        sp_in = 32'h3000; pc_in = 24'h000777; ccr_in = 8'h01;
        trap_req = 1'b1; trap_vec = 8'd3;
        exp_entry(32'h3000, 8'h01, 24'h000777, 8'd3, "R5 trap");
        exp_entry(32'h2FFC, 8'h81, hnd(32'd12), 8'd30, "R5 chained irq");
        @(negedge clk);
        trap_req = 1'b0; irq_req = 1'b1; irq_vec = 8'd30;
        wait_load();
        @(negedge clk);
        chk("R5 chained entry", 32'(busy), 32'd1);
        irq_req = 1'b0;
        wait_idle();

        // R12: reset during a push abandons it.
        sp_in = 32'h5000; irq_req = 1'b1; irq_vec = 8'd7; insn_end = 1'b1;
        @(negedge clk);
        irq_req = 1'b0; insn_end = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R12 request dropped", 32'(bus_req), 32'd0);
        chk("R12 busy in reset", 32'(busy), 32'd1);
        @(negedge clk);
        push_item(1, 32'h0, 32'h0, "R12 vector 0");
        push_item(2, 32'h0, {8'h80, hnd(32'h0)}, "R12 reset load");
        rst_n = 1'b1;
        wait_load();
        @(negedge clk);
        chk("R12 idle after re-entry", 32'(busy), 32'd0);

        repeat (4) @(negedge clk);
        chk("R9 all expected traffic seen", 32'(exp_q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule